// File: doc/BRIEF.md
# Flash command sequence controller

This block is the command front end of a two-bank parallel NOR flash model. It watches host write cycles on an active-low chip select, an active-low write enable and the address and data buses. It turns the accepted cycles into commands through a sequence decoder and keeps one mode machine per bank. A read-side selector tells the data path what each read returns: array contents, status, or identification codes. The choice follows the mode of the bank that owns the read address and, in suspended-erase reading, whether the address falls in the suspended sector.

A write cycle lasts while both strobes are low. The address is taken when the second strobe falls and the data is taken when the first strobe rises. The decoder uses the two unlock cycles, 0xAA at low address 0x555 and then 0x55 at low address 0x2AA. After them comes a command byte: 0x90 enters identification mode, 0xA0 arms a program (the next write gives the target), and 0x80 followed by a second unlock pair and 0x30 at a sector address starts a sector erase. Three single-cycle commands need no unlock: 0xF0 (reset), 0xB0 (suspend an erase) and 0x30 (resume it). The bank is picked by the top address bit, and the top `SECT_W` address bits name a sector. A down-counter stands in for the embedded program and erase time. A test input forces the error outcome of a busy bank.

Decoder states: `SEQ_IDLE`, `SEQ_GOT_AA`, `SEQ_GOT_55`, `SEQ_PROG_DATA`, `SEQ_ERS_AA`, `SEQ_ERS_55`, `SEQ_ERS_GO`. A correct cycle advances along the unlock, command and target chain. Any reset byte, and any wrong value, returns the decoder to `SEQ_IDLE`. Bank states and their transitions:
- `MODE_READ` goes to `MODE_AUTOSEL`, `MODE_PROG` or `MODE_ERASE`.
- `MODE_AUTOSEL` goes to `MODE_READ` or `MODE_SUSP_READ` on reset.
- `MODE_SUSP_READ` goes to `MODE_AUTOSEL` or `MODE_PROG`, or to `MODE_ERASE` on resume.
- `MODE_PROG` goes to its return mode when the count ends, or to `MODE_ERROR` on injection.
- `MODE_ERASE` goes to `MODE_READ` when the count ends, to `MODE_SUSP_READ` on suspend, or to `MODE_ERROR` on injection.
- `MODE_ERROR` goes to its return mode on reset.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset both banks report mode code 0 (read). The mode codes on `bank_mode_o` are: 0 read, 1 identification, 2 suspended-erase read, 3 programming, 4 erasing, 5 error. Bank 0 uses bits [2:0] and bank 1 uses bits [5:3].
- R2: A write is the span in which `cs_n_i` and `we_n_i` are both low. Its address is the bus value when the later strobe falls. Its data is the bus value in the last cycle before the first strobe rises, so data driven after the rise is not used.
- R3: The writes 0xAA at low address 0x555, 0x55 at 0x2AA, then 0x90 at an address of a bank put that bank in mode 1. Reads from that bank select code 2 (identification) for any number of reads.
- R4: A reset byte 0xF0 written part-way through a program, erase or identification sequence aborts it. No operation starts, and the bank stays in mode 0, or in mode 2 if it was in suspended-erase read.
- R5: A bank in mode 1 leaves only on a reset byte. It goes to mode 0, or to mode 2 if it entered from mode 2.
- R6: Once a program has started (mode 3), reset bytes are ignored. After `PROG_CYCLES` cycles the bank returns to mode 0, or to mode 2 if it programmed from suspended-erase read.
- R7: Read select codes on `rd_sel_o` are 0 array, 1 status, 2 identification; 3 never appears. Modes 3, 4 and 5 select 1. In mode 2 the suspended sector selects 1 and other sectors select 0.
- R8: The address of a reset byte is ignored, and one reset acts on both banks.
- R9: A wrong address or data value anywhere in a sequence drops the partial sequence, and the following writes start no operation.
- R10: An identification sequence aimed at one bank is rejected while the other bank is in mode 3 or 4.
- R11: With `err_inject_i` high, a busy bank goes to mode 5. It stays there until a reset byte returns it to mode 0, or to mode 2 if an erase was suspended.
- R12: The erase sequence (unlock, 0x80, unlock, 0x30 at a sector address) puts the bank in mode 4 for `ERASE_CYCLES` cycles. 0xB0 to that bank moves it to mode 2 with its remaining time frozen. 0x30 to the bank resumes mode 4 with that remaining time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n_i | input | 1 | Host chip select, active low |
| we_n_i | input | 1 | Host write enable, active low |
| addr_i | input | ADDR_W | Host address bus |
| data_i | input | DATA_W | Host write data bus |
| err_inject_i | input | 1 | Test input forcing the error outcome of a busy bank |
| rd_sector_i | input | SECT_W | Top address bits of the current read (MSB is the bank) |
| rd_sel_o | output | 2 | Read source select for the current read |
| bank_mode_o | output | 6 | Mode code of each bank, 3 bits per bank |

## Verification
The bench builds the block with `PROG_CYCLES` = 40 and `ERASE_CYCLES` = 120. Both are short enough that the end of a program and of a resumed erase is seen within the run. The program time is still long enough that a complete three-write identification sequence fits inside the busy window of the other bank, which is what makes the R10 rejection reachable. The erase time leaves room to suspend a running erase, then identify, program, fail and recover inside the suspended state before resuming it.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    localparam int NUM_BANKS = 2;
    localparam int MODE_W    = 3;
    localparam int LOW_AW    = 11;

    typedef enum logic [2:0] {
        MODE_READ      = 3'd0,
        MODE_AUTOSEL   = 3'd1,
        MODE_SUSP_READ = 3'd2,
        MODE_PROG      = 3'd3,
        MODE_ERASE     = 3'd4,
        MODE_ERROR     = 3'd5
    } bank_mode_e;

    typedef enum logic [1:0] {
        SEL_ARRAY  = 2'd0,
        SEL_STATUS = 2'd1,
        SEL_IDCODE = 2'd2,
        SEL_RSVD   = 2'd3
    } rd_sel_e;

    typedef enum logic [2:0] {
        CMD_NONE    = 3'd0,
        CMD_RESET   = 3'd1,
        CMD_AUTOSEL = 3'd2,
        CMD_PROGRAM = 3'd3,
        CMD_ERASE   = 3'd4,
        CMD_SUSPEND = 3'd5,
        CMD_RESUME  = 3'd6
    } cmd_kind_e;

    localparam logic [7:0] BYTE_UNLOCK_A = 8'hAA;
    localparam logic [7:0] BYTE_UNLOCK_B = 8'h55;
    localparam logic [7:0] BYTE_RESET    = 8'hF0;
    localparam logic [7:0] BYTE_AUTOSEL  = 8'h90;
    localparam logic [7:0] BYTE_PROGRAM  = 8'hA0;
    localparam logic [7:0] BYTE_ERS_SET  = 8'h80;
    localparam logic [7:0] BYTE_ERS_GO   = 8'h30;
    localparam logic [7:0] BYTE_SUSPEND  = 8'hB0;
    localparam logic [7:0] BYTE_RESUME   = 8'h30;

    localparam logic [LOW_AW-1:0] ADDR_UNLOCK_A = 11'h555;
    localparam logic [LOW_AW-1:0] ADDR_UNLOCK_B = 11'h2AA;

endpackage

// File: rtl/flash_bus_capture.sv
module flash_bus_capture #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_i,
    input  logic              we_n_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              wr_valid_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [DATA_W-1:0] wr_data_o
);

    logic              strobe_on;
    logic              strobe_q;
    logic [ADDR_W-1:0] addr_hold_q;
    logic [DATA_W-1:0] data_hold_q;

    // A write cycle exists only while both strobes are low.
    assign strobe_on = !cs_n_i && !we_n_i;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strobe_q    <= 1'b0;
            addr_hold_q <= '0;
            data_hold_q <= '0;
            wr_valid_o  <= 1'b0;
            wr_addr_o   <= '0;
            wr_data_o   <= '0;
        end else begin
            strobe_q   <= strobe_on;
            wr_valid_o <= strobe_q && !strobe_on;
            // later falling strobe opens the cycle: take the address
            if (strobe_on && !strobe_q) begin
                addr_hold_q <= addr_i;
            end
            // data keeps following the bus until the first strobe rises
            if (strobe_on) begin
                data_hold_q <= data_i;
            end
            if (strobe_q && !strobe_on) begin
                wr_addr_o <= addr_hold_q;
                wr_data_o <= data_hold_q;
            end
        end
    end

    // R2: one completed write yields exactly one single-cycle pulse
    assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid_o |=> !wr_valid_o);

endmodule

// File: rtl/flash_seq_decoder.sv
module flash_seq_decoder
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 8,
    parameter int SECT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output cmd_kind_e         cmd_kind_o,
    output logic [SECT_W-1:0] cmd_sector_o
);

    typedef enum logic [2:0] {
        SEQ_IDLE      = 3'd0,
        SEQ_GOT_AA    = 3'd1,
        SEQ_GOT_55    = 3'd2,
        SEQ_PROG_DATA = 3'd3,
        SEQ_ERS_AA    = 3'd4,
        SEQ_ERS_55    = 3'd5,
        SEQ_ERS_GO    = 3'd6
    } seq_e;

    seq_e              seq_q, seq_d;
    cmd_kind_e         kind_d;
    logic [7:0]        cmd_byte;
    logic [LOW_AW-1:0] low_addr;
    logic              is_unlock_a;
    logic              is_unlock_b;

    assign cmd_byte    = wr_data_i[7:0];
    assign low_addr    = wr_addr_i[LOW_AW-1:0];
    assign is_unlock_a = (cmd_byte == BYTE_UNLOCK_A) && (low_addr == ADDR_UNLOCK_A);
    assign is_unlock_b = (cmd_byte == BYTE_UNLOCK_B) && (low_addr == ADDR_UNLOCK_B);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q        <= SEQ_IDLE;
            cmd_kind_o   <= CMD_NONE;
            cmd_sector_o <= '0;
        end else begin
            seq_q        <= seq_d;
            cmd_kind_o   <= kind_d;
            if (wr_valid_i) begin
                cmd_sector_o <= wr_addr_i[ADDR_W-1 -: SECT_W];
            end
        end
    end

    always_comb begin
        seq_d  = seq_q;
        kind_d = CMD_NONE;
        if (wr_valid_i) begin
            if (cmd_byte == BYTE_RESET) begin
                // reset is taken at any point, address ignored
                kind_d = CMD_RESET;
                seq_d  = SEQ_IDLE;
            end else begin
                unique case (seq_q)
                    SEQ_IDLE: begin
                        if (is_unlock_a) begin
                            seq_d = SEQ_GOT_AA;
                        end else if (cmd_byte == BYTE_SUSPEND) begin
                            kind_d = CMD_SUSPEND;
                        end else if (cmd_byte == BYTE_RESUME) begin
                            kind_d = CMD_RESUME;
                        end
                    end
                    SEQ_GOT_AA: begin
                        seq_d = is_unlock_b ? SEQ_GOT_55 : SEQ_IDLE;
                    end
                    SEQ_GOT_55: begin
                        seq_d = SEQ_IDLE;
                        if (cmd_byte == BYTE_AUTOSEL) begin
                            kind_d = CMD_AUTOSEL;
                        end else if (cmd_byte == BYTE_PROGRAM) begin
                            seq_d = SEQ_PROG_DATA;
                        end else if (cmd_byte == BYTE_ERS_SET) begin
                            seq_d = SEQ_ERS_AA;
                        end
                    end
                    SEQ_PROG_DATA: begin
                        kind_d = CMD_PROGRAM;
                        seq_d  = SEQ_IDLE;
                    end
                    SEQ_ERS_AA: begin
                        seq_d = is_unlock_a ? SEQ_ERS_55 : SEQ_IDLE;
                    end
                    SEQ_ERS_55: begin
                        seq_d = is_unlock_b ? SEQ_ERS_GO : SEQ_IDLE;
                    end
                    SEQ_ERS_GO: begin
                        seq_d = SEQ_IDLE;
                        if (cmd_byte == BYTE_ERS_GO) begin
                            kind_d = CMD_ERASE;
                        end
                    end
                    default: seq_d = SEQ_IDLE;
                endcase
            end
        end
    end

    // R9: a wrong second unlock cycle drops the partial sequence
    assert_bad_unlock_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q == SEQ_GOT_AA && wr_valid_i && !is_unlock_b) |=> seq_q == SEQ_IDLE);

    // R9: a wrong command byte after the unlock pair issues nothing
    assert_bad_code_no_cmd_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q == SEQ_GOT_55 && wr_valid_i && cmd_byte != BYTE_AUTOSEL && cmd_byte != BYTE_RESET)
        |=> cmd_kind_o == CMD_NONE);

endmodule

// File: rtl/flash_bank_fsm.sv
module flash_bank_fsm
    import flash_cmd_pkg::*;
#(
    parameter int BANK_IDX     = 0,
    parameter int SECT_W       = 3,
    parameter int PROG_CYCLES  = 16,
    parameter int ERASE_CYCLES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cmd_kind_e         cmd_kind_i,
    input  logic [SECT_W-1:0] cmd_sector_i,
    input  logic              err_inject_i,
    input  logic              other_busy_i,
    output bank_mode_e        mode_o,
    output logic              busy_o,
    output logic [SECT_W-1:0] susp_sector_o
);

    localparam int MAX_CYC = (ERASE_CYCLES > PROG_CYCLES) ? ERASE_CYCLES : PROG_CYCLES;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] PROG_LOAD  = CNT_W'(PROG_CYCLES - 1);
    localparam logic [CNT_W-1:0] ERASE_LOAD = CNT_W'(ERASE_CYCLES - 1);
    localparam logic MY_BANK = 1'(BANK_IDX);

    bank_mode_e        mode_q, mode_d;
    bank_mode_e        ret_mode;
    logic [CNT_W-1:0]  prog_cnt_q, prog_cnt_d;
    logic [CNT_W-1:0]  ers_cnt_q, ers_cnt_d;
    logic              susp_q, susp_d;
    logic [SECT_W-1:0] sect_q, sect_d;
    logic              own;
    logic              is_reset;

    assign own      = (cmd_sector_i[SECT_W-1] == MY_BANK);
    assign is_reset = (cmd_kind_i == CMD_RESET);
    assign ret_mode = susp_q ? MODE_SUSP_READ : MODE_READ;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q     <= MODE_READ;
            prog_cnt_q <= '0;
            ers_cnt_q  <= '0;
            susp_q     <= 1'b0;
            sect_q     <= '0;
        end else begin
            mode_q     <= mode_d;
            prog_cnt_q <= prog_cnt_d;
            ers_cnt_q  <= ers_cnt_d;
            susp_q     <= susp_d;
            sect_q     <= sect_d;
        end
    end

    always_comb begin
        mode_d     = mode_q;
        prog_cnt_d = prog_cnt_q;
        ers_cnt_d  = ers_cnt_q;
        susp_d     = susp_q;
        sect_d     = sect_q;
        unique case (mode_q)
            MODE_READ: begin
                if (own && cmd_kind_i == CMD_AUTOSEL && !other_busy_i) begin
                    mode_d = MODE_AUTOSEL;
                end else if (own && cmd_kind_i == CMD_PROGRAM) begin
                    mode_d     = MODE_PROG;
                    prog_cnt_d = PROG_LOAD;
                end else if (own && cmd_kind_i == CMD_ERASE) begin
                    mode_d    = MODE_ERASE;
                    ers_cnt_d = ERASE_LOAD;
                    sect_d    = cmd_sector_i;
                end
            end
            MODE_AUTOSEL: begin
                if (is_reset) begin
                    mode_d = ret_mode;
                end
            end
            MODE_SUSP_READ: begin
                if (own && cmd_kind_i == CMD_AUTOSEL && !other_busy_i) begin
                    mode_d = MODE_AUTOSEL;
                end else if (own && cmd_kind_i == CMD_PROGRAM) begin
                    mode_d     = MODE_PROG;
                    prog_cnt_d = PROG_LOAD;
                end else if (own && cmd_kind_i == CMD_RESUME) begin
                    mode_d = MODE_ERASE;
                    susp_d = 1'b0;
                end
            end
            MODE_PROG: begin
                if (err_inject_i) begin
                    mode_d = MODE_ERROR;
                end else if (prog_cnt_q == '0) begin
                    mode_d = ret_mode;
                end else begin
                    prog_cnt_d = prog_cnt_q - 1'b1;
                end
            end
            MODE_ERASE: begin
                if (err_inject_i) begin
                    mode_d = MODE_ERROR;
                end else if (own && cmd_kind_i == CMD_SUSPEND) begin
                    mode_d = MODE_SUSP_READ;
                    susp_d = 1'b1;
                end else if (ers_cnt_q == '0) begin
                    mode_d = MODE_READ;
                end else begin
                    ers_cnt_d = ers_cnt_q - 1'b1;
                end
            end
            MODE_ERROR: begin
                if (is_reset) begin
                    mode_d = ret_mode;
                end
            end
            default: mode_d = MODE_READ;
        endcase
    end

    assign mode_o        = mode_q;
    assign busy_o        = (mode_q == MODE_PROG) || (mode_q == MODE_ERASE);
    assign susp_sector_o = sect_q;

    // R5: identification mode is left only through a reset
    assert_autosel_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_AUTOSEL && !is_reset) |=> mode_q == MODE_AUTOSEL);

    // R5: leaving identification with a suspended erase lands in suspended read
    assert_autosel_to_susp_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_AUTOSEL && is_reset && susp_q) |=> mode_q == MODE_SUSP_READ);

    // R6: a running program does not react to reset
    assert_busy_ignores_reset_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_PROG && is_reset && !err_inject_i && prog_cnt_q != '0)
        |=> mode_q == MODE_PROG);

    // R10: identification is refused while the other bank is busy
    assert_autosel_blocked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_READ && own && cmd_kind_i == CMD_AUTOSEL && other_busy_i)
        |=> mode_q == MODE_READ);

    // R11: error is sticky until a reset
    assert_error_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_ERROR && !is_reset) |=> mode_q == MODE_ERROR);

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W       = 12,
    parameter int DATA_W       = 8,
    parameter int SECT_W       = 3,
    parameter int PROG_CYCLES  = 16,
    parameter int ERASE_CYCLES = 64
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cs_n_i,
    input  logic                        we_n_i,
    input  logic [ADDR_W-1:0]           addr_i,
    input  logic [DATA_W-1:0]           data_i,
    input  logic                        err_inject_i,
    input  logic [SECT_W-1:0]           rd_sector_i,
    output logic [1:0]                  rd_sel_o,
    output logic [NUM_BANKS*MODE_W-1:0] bank_mode_o
);

    logic              wr_valid;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    cmd_kind_e         cmd_kind;
    logic [SECT_W-1:0] cmd_sector;

    bank_mode_e        bank_mode [NUM_BANKS];
    logic              bank_busy [NUM_BANKS];
    logic [SECT_W-1:0] bank_sect [NUM_BANKS];

    bank_mode_e        rd_mode;
    logic [SECT_W-1:0] rd_susp_sect;
    rd_sel_e           rd_sel;

    flash_bus_capture #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) bus_cap_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n_i     (cs_n_i),
        .we_n_i     (we_n_i),
        .addr_i     (addr_i),
        .data_i     (data_i),
        .wr_valid_o (wr_valid),
        .wr_addr_o  (wr_addr),
        .wr_data_o  (wr_data)
    );

    flash_seq_decoder #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .SECT_W (SECT_W)
    ) seq_dec_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_valid_i   (wr_valid),
        .wr_addr_i    (wr_addr),
        .wr_data_i    (wr_data),
        .cmd_kind_o   (cmd_kind),
        .cmd_sector_o (cmd_sector)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        flash_bank_fsm #(
            .BANK_IDX     (b),
            .SECT_W       (SECT_W),
            .PROG_CYCLES  (PROG_CYCLES),
            .ERASE_CYCLES (ERASE_CYCLES)
        ) bank_i (
            .clk           (clk),
            .rst_n         (rst_n),
            .cmd_kind_i    (cmd_kind),
            .cmd_sector_i  (cmd_sector),
            .err_inject_i  (err_inject_i),
            .other_busy_i  (bank_busy[NUM_BANKS-1-b]),
            .mode_o        (bank_mode[b]),
            .busy_o        (bank_busy[b]),
            .susp_sector_o (bank_sect[b])
        );
        assign bank_mode_o[b*MODE_W +: MODE_W] = bank_mode[b];
    end

    assign rd_mode      = bank_mode[rd_sector_i[SECT_W-1]];
    assign rd_susp_sect = bank_sect[rd_sector_i[SECT_W-1]];

    always_comb begin
        unique case (rd_mode)
            MODE_READ:      rd_sel = SEL_ARRAY;
            MODE_AUTOSEL:   rd_sel = SEL_IDCODE;
            MODE_SUSP_READ: rd_sel = (rd_sector_i == rd_susp_sect) ? SEL_STATUS : SEL_ARRAY;
            MODE_PROG,
            MODE_ERASE,
            MODE_ERROR:     rd_sel = SEL_STATUS;
            default:        rd_sel = SEL_STATUS;
        endcase
    end

    assign rd_sel_o = rd_sel;

    // R7: the reserved select code never reaches the read path
    assert_rd_sel_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_sel_o != SEL_RSVD);

    // R1: the cycle after reset releases, both banks are still in read
    assert_powerup_read_R1: assert property (@(posedge clk)
        !rst_n |=> bank_mode_o == '0);

endmodule

// File: tb/flash_cmd_ctrl_tb.sv
`timescale 1ns/1ps
module flash_cmd_ctrl_tb_top;

    localparam int ADDR_W = 12;
    localparam int DATA_W = 8;
    localparam int SECT_W = 3;
    localparam int PROG   = 40;
    localparam int ERASE  = 120;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cs_n = 1'b1;
    logic              we_n = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic [DATA_W-1:0] data = '0;
    logic              err_inj = 1'b0;
    logic [SECT_W-1:0] rd_sector = '0;
    logic [1:0]        rd_sel;
    logic [5:0]        modes;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done  = 0;

    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic [7:0] cur_e;
    string      cur_t;

    always #2 clk = ~clk;

    flash_cmd_ctrl #(
        .ADDR_W       (ADDR_W),
        .DATA_W       (DATA_W),
        .SECT_W       (SECT_W),
        .PROG_CYCLES  (PROG),
        .ERASE_CYCLES (ERASE)
    ) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .cs_n_i       (cs_n),
        .we_n_i       (we_n),
        .addr_i       (addr),
        .data_i       (data),
        .err_inject_i (err_inj),
        .rd_sector_i  (rd_sector),
        .rd_sel_o     (rd_sel),
        .bank_mode_o  (modes)
    );

    // monitor: pops one expected item per falling edge and compares
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            cur_e = exp_q.pop_front();
            cur_t = tag_q.pop_front();
            n_cmp++;
            if ({modes[2:0], modes[5:3], rd_sel} != cur_e) begin
                n_bad++;
                $display("FAIL %s: got m0=%0d m1=%0d sel=%0d expected m0=%0d m1=%0d sel=%0d",
                         cur_t, modes[2:0], modes[5:3], rd_sel,
                         cur_e[7:5], cur_e[4:2], cur_e[1:0]);
            end
        end
    end

    task automatic expect_st(input string tag, input logic [2:0] sec,
                             input logic [2:0] m0, input logic [2:0] m1,
                             input logic [1:0] sel);
        @(posedge clk); #1;
        rd_sector = sec;
        exp_q.push_back({m0, m1, sel});
        tag_q.push_back(tag);
        @(negedge clk); #1;
    endtask

    // chip select falls first with a junk address; write enable rises
    // first and junk data follows before chip select rises
    task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        cs_n = 1'b0; addr = 12'h7E1; data = 8'hFF;
        @(posedge clk); #1;
        we_n = 1'b0; addr = a; data = d;
        @(posedge clk); #1;
        @(posedge clk); #1;
        we_n = 1'b1; addr = 12'h0F3; data = 8'h00;
        @(posedge clk); #1;
        cs_n = 1'b1;
    endtask

    task automatic settle();
        repeat (4) @(posedge clk);
    endtask

    task automatic unlock();
        wr(12'h555, 8'hAA);
        wr(12'h2AA, 8'h55);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic pulse_err();
        @(posedge clk); #1; err_inj = 1'b1;
        @(posedge clk); #1; err_inj = 1'b0;
    endtask

    initial begin
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        settle();
        expect_st("R1 reset state bank0", 3'd0, 3'd0, 3'd0, 2'd0);
        expect_st("R1 reset state bank1", 3'd5, 3'd0, 3'd0, 2'd0);

        // identification on bank 0
        unlock(); wr(12'h000, 8'h90); settle();
        expect_st("R2 R3 identification entered", 3'd0, 3'd1, 3'd0, 2'd2);
        expect_st("R3 other bank reads array", 3'd4, 3'd1, 3'd0, 2'd0);
        expect_st("R3 repeated code read", 3'd1, 3'd1, 3'd0, 2'd2);
        wr(12'h6C3, 8'hF0); settle();
        expect_st("R5 R8 reset leaves identification", 3'd0, 3'd0, 3'd0, 2'd0);

        // program on bank 1, reset ignored while busy
        unlock(); wr(12'h800, 8'hA0); wr(12'hA00, 8'h12); settle();
        expect_st("R6 program running", 3'd5, 3'd0, 3'd3, 2'd1);
        wr(12'h000, 8'hF0); settle();
        expect_st("R6 reset ignored while programming", 3'd5, 3'd0, 3'd3, 2'd1);
        wait_cyc(50);
        expect_st("R6 program completes", 3'd5, 3'd0, 3'd0, 2'd0);

        // wrong values drop the sequence
        wr(12'h555, 8'hAA); wr(12'h2AB, 8'h55); wr(12'h800, 8'hA0); wr(12'hA00, 8'h12); settle();
        expect_st("R9 wrong unlock address", 3'd5, 3'd0, 3'd0, 2'd0);
        unlock(); wr(12'h800, 8'h77); wr(12'hA00, 8'h12); settle();
        expect_st("R9 wrong command byte", 3'd5, 3'd0, 3'd0, 2'd0);

        // reset mid-sequence
        unlock(); wr(12'h800, 8'hA0); wr(12'h000, 8'hF0); wr(12'hA00, 8'h34); settle();
        expect_st("R4 program sequence aborted", 3'd5, 3'd0, 3'd0, 2'd0);
        unlock(); wr(12'h000, 8'h80); wr(12'h555, 8'hAA); wr(12'h000, 8'hF0); wr(12'h200, 8'h30); settle();
        expect_st("R4 erase sequence aborted", 3'd1, 3'd0, 3'd0, 2'd0);

        // erase bank 0 sector 1, suspend
        unlock(); wr(12'h000, 8'h80); unlock(); wr(12'h200, 8'h30); settle();
        expect_st("R12 erase running", 3'd1, 3'd4, 3'd0, 2'd1);
        wr(12'h000, 8'hB0); settle();
        expect_st("R12 R7 suspended sector gives status", 3'd1, 3'd2, 3'd0, 2'd1);
        expect_st("R7 other sector gives array", 3'd2, 3'd2, 3'd0, 2'd0);
        wait_cyc(150);
        expect_st("R12 suspended erase frozen", 3'd1, 3'd2, 3'd0, 2'd1);

        unlock(); wr(12'h000, 8'h90); settle();
        expect_st("R5 identification from suspend", 3'd0, 3'd1, 3'd0, 2'd2);
        wr(12'h000, 8'hF0); settle();
        expect_st("R5 reset returns to suspended read", 3'd1, 3'd2, 3'd0, 2'd1);

        unlock(); wr(12'h000, 8'hA0); wr(12'h400, 8'h12); settle();
        expect_st("R6 program from suspend", 3'd2, 3'd3, 3'd0, 2'd1);
        wait_cyc(50);
        expect_st("R6 program returns to suspended read", 3'd2, 3'd2, 3'd0, 2'd0);

        unlock(); wr(12'h000, 8'hA0); wr(12'h000, 8'hF0); wr(12'h400, 8'h34); settle();
        expect_st("R4 abort keeps suspended read", 3'd2, 3'd2, 3'd0, 2'd0);

        unlock(); wr(12'h000, 8'hA0); wr(12'h400, 8'h12); settle();
        pulse_err(); settle();
        expect_st("R11 error from program", 3'd2, 3'd5, 3'd0, 2'd1);
        wait_cyc(60);
        expect_st("R11 error sticky", 3'd2, 3'd5, 3'd0, 2'd1);
        wr(12'h000, 8'hF0); settle();
        expect_st("R11 reset returns to suspended read", 3'd1, 3'd2, 3'd0, 2'd1);

        wr(12'h000, 8'h30); settle();
        expect_st("R12 erase resumed", 3'd1, 3'd4, 3'd0, 2'd1);
        wait_cyc(130);
        expect_st("R12 erase completes", 3'd1, 3'd0, 3'd0, 2'd0);

        // identification refused while the other bank programs
        unlock(); wr(12'h800, 8'hA0); wr(12'hA00, 8'h12); settle();
        unlock(); wr(12'h000, 8'h90); settle();
        expect_st("R10 identification refused", 3'd0, 3'd0, 3'd3, 2'd0);
        wait_cyc(60);
        expect_st("R10 program done", 3'd5, 3'd0, 3'd0, 2'd0);

        // erase error on bank 1, one reset clears both banks
        unlock(); wr(12'h800, 8'h80); unlock(); wr(12'hC00, 8'h30); settle();
        pulse_err(); settle();
        expect_st("R11 error from erase", 3'd6, 3'd0, 3'd5, 2'd1);
        unlock(); wr(12'h000, 8'h90); settle();
        expect_st("R8 bank0 identification, bank1 error", 3'd0, 3'd1, 3'd5, 2'd2);
        wr(12'hFFF, 8'hF0); settle();
        expect_st("R8 reset clears both banks", 3'd6, 3'd0, 3'd0, 2'd0);

        wait_cyc(4);
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got no finish expected finish within limit");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule